// File: doc/BRIEF.md
# Four-Channel PWM Idle and Output-State Controller

This block sits between four pulse-width-to-code converters and four DAC output stages. For every channel it watches the synchronized PWM input for missing rising edges, accepts new codes from the converter only when they come from a pair of rising edges closer together than the idle timeout, and decides what the channel presents: a driven code, zero-scale, full-scale, a held code, or powered down with its output in high impedance. It also derives a power-down flag for the shared internal reference.

A strap input picks one of two personalities. In transparent mode the outputs always drive: power-on and an idle-low input give zero-scale, and an idle-high input gives full-scale. In sample/hold mode the channels start powered down, an idle-high input keeps the last accepted code, and an idle-low input powers the channel down. An active-low sleep input forces every channel and the reference off; on release, transparent mode drives again at once, while sample/hold mode keeps each channel off until it receives a valid code, which takes two fresh rising edges. The timeout is counted in ticks of a shared prescaler; each channel has its own tick counter, cleared by a rising edge and by a falling edge seen after the channel went idle, that raises a sticky idle flag at terminal count.

Each channel runs a state machine with the states INIT (reset, shows the mode's power-on state), OFF (powered down, high impedance), ZERO, FULL, DRIVE (last accepted code) and HOLD (last accepted code kept through an idle-high input). Transitions: INIT goes to ZERO in transparent mode and to OFF in sample/hold mode; any state goes to OFF while sleep is asserted; OFF goes to ZERO in transparent mode; any state goes to DRIVE on an accepted code; on a timeout expiry ZERO, FULL, DRIVE and HOLD go to FULL or ZERO (transparent, input high or low) and to HOLD or OFF (sample/hold, input high or low), while OFF stays OFF.

Top module: `pwm_idle_ctrl`

## Requirements
- R1: After reset in transparent mode (`hold_mode`=0) every channel has `drive_en`=1, `chan_off`=0 and code 0; in sample/hold mode (`hold_mode`=1) every channel has `drive_en`=0, `chan_off`=1 and code 0.
- R2: A `conv_valid` strobe is accepted when the two latest rising edges of that channel were closer than the timeout; from the clock after the strobe the channel drives that code with `drive_en`=1 and `chan_off`=0. Channel n's code occupies `dac_code[n*CODE_W +: CODE_W]`.
- R3: A strobe is ignored (output unchanged) when the channel has seen no rising edge since reset or sleep, when only one edge has arrived, or when the latest edge came more than the timeout after the one before it.
- R4: A channel goes idle when no rising edge has arrived for TIMEOUT_TICKS prescaler ticks of PRESCALE clocks; the state change appears between (TIMEOUT_TICKS-1)*PRESCALE+1 and TIMEOUT_TICKS*PRESCALE clocks after the rising edge.
- R5: In transparent mode an idle channel shows code 0 if its input is low and all-ones if high; from full-scale, a fall followed by a low input for the timeout gives code 0, and the timeout restarts at that fall.
- R6: In sample/hold mode an idle channel with a high input keeps its last accepted code; with a low input it goes to `drive_en`=0, `chan_off`=1, code 0; a powered-down channel stays powered down when its input idles high. A powered-down channel always shows code 0.
- R7: While `sleep_n` is low, from the next clock every channel has `drive_en`=0 and `chan_off`=1, `ref_off`=1, and strobes are ignored.
- R8: After `sleep_n` returns high, transparent mode drives code 0 on every channel from the next clock; sample/hold mode keeps each channel powered down until it accepts a code, which needs two rising edges after the release.
- R9: `ref_off` is 1 when `ext_ref` is 1 or all channels have `chan_off`=1, otherwise 0.
- R10: An accepted strobe in the same clock as a timeout expiry wins: the channel drives the new code, and it stays so until the next event.
- R11: Events on one channel do not change any other channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hold_mode | input | 1 | Strap: 0 transparent, 1 sample/hold |
| sleep_n | input | 1 | Active-low global power-down |
| ext_ref | input | 1 | 1 when an external reference is in use |
| pwm_level | input | NUM_CH | Synchronized PWM level per channel |
| pwm_rise | input | NUM_CH | One-clock pulse per channel on a rising edge |
| conv_valid | input | NUM_CH | New-code strobe per channel from the converter |
| conv_code | input | NUM_CH*CODE_W | Converter codes, channel n at bits n*CODE_W upward |
| dac_code | output | NUM_CH*CODE_W | Final code per channel, same packing |
| drive_en | output | NUM_CH | Output stage drives the pin |
| chan_off | output | NUM_CH | Channel powered down |
| ref_off | output | 1 | Internal reference powered down |

## Verification
The hardest situation to reach is a code strobe landing in exactly the clock where the timeout expires, because the expiry moment depends on the free-running prescaler phase, which is not visible at the ports. The bench first lets a driven channel time out and records at which clock after the second rising edge the output falls to zero, then repeats the edge pair a whole number of prescaler periods later so the phase matches and places the strobe in that recorded clock. The same measurement doubles as the check of the timeout window.

// File: rtl/pwm_idle_pkg.sv
package pwm_idle_pkg;

    typedef enum logic [2:0] {
        CH_INIT  = 3'd0,
        CH_OFF   = 3'd1,
        CH_ZERO  = 3'd2,
        CH_FULL  = 3'd3,
        CH_DRIVE = 3'd4,
        CH_HOLD  = 3'd5
    } ch_state_e;

endpackage

// File: rtl/idle_tick_gen.sv
module idle_tick_gen #(
    parameter int PRESCALE = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] div_q;

    assign tick_o = (div_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (tick_o) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
    parameter int TIMEOUT_TICKS = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic clr_i,
    output logic idle_o,
    output logic expire_o
);
    localparam int CW = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          idle_q;

    // expiry is a one-clock event; a clear in the same clock cancels it
    assign expire_o = tick_i && !idle_q && !clr_i && (cnt_q == LAST);
    assign idle_o   = idle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idle_q <= 1'b0;
        end else if (clr_i) begin
            cnt_q  <= '0;
            idle_q <= 1'b0;
        end else if (expire_o) begin
            cnt_q  <= '0;
            idle_q <= 1'b1;
        end else if (tick_i && !idle_q) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/chan_ctrl.sv
module chan_ctrl
    import pwm_idle_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_mode,
    input  logic              sleep_n,
    input  logic              lvl_i,
    input  logic              rise_i,
    input  logic              code_vld_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              idle_i,
    input  logic              expire_i,
    output logic              timer_clr_o,
    output logic [CODE_W-1:0] code_o,
    output logic              oe_o,
    output logic              off_o
);
    localparam logic [CODE_W-1:0] FULL_CODE = {CODE_W{1'b1}};

    ch_state_e         state_q, state_d, idle_target;
    logic [CODE_W-1:0] code_q;
    logic              armed_q;
    logic              pair_ok_q;
    logic              lvl_q;
    logic              fall;
    logic              accept;

    assign fall        = lvl_q && !lvl_i;
    assign timer_clr_o = rise_i || (fall && idle_i) || !sleep_n;
    assign accept      = code_vld_i && pair_ok_q && sleep_n;

    always_comb begin
        if (hold_mode) begin
            idle_target = lvl_i ? CH_HOLD : CH_OFF;
        end else begin
            idle_target = lvl_i ? CH_FULL : CH_ZERO;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!sleep_n) begin
            state_d = CH_OFF;
        end else if (accept) begin
            state_d = CH_DRIVE;
        end else begin
            unique case (state_q)
                CH_INIT:  state_d = hold_mode ? CH_OFF : CH_ZERO;
                CH_OFF: begin
                    if (!hold_mode) begin
                        state_d = CH_ZERO;
                    end
                end
                CH_ZERO, CH_FULL, CH_DRIVE, CH_HOLD: begin
                    if (expire_i) begin
                        state_d = idle_target;
                    end
                end
                default:  state_d = CH_INIT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_INIT;
        end else begin
            state_q <= state_d;
        end
    end

    // edge pairing and code capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q    <= '0;
            armed_q   <= 1'b0;
            pair_ok_q <= 1'b0;
            lvl_q     <= 1'b0;
        end else begin
            lvl_q <= lvl_i;
            if (!sleep_n) begin
                armed_q   <= 1'b0;
                pair_ok_q <= 1'b0;
            end else if (rise_i) begin
                pair_ok_q <= armed_q;
                armed_q   <= 1'b1;
            end else if (expire_i) begin
                armed_q   <= 1'b0;
                pair_ok_q <= 1'b0;
            end
            if (accept) begin
                code_q <= code_i;
            end
        end
    end

    // outputs
    always_comb begin
        code_o = '0;
        oe_o   = 1'b0;
        off_o  = 1'b1;
        unique case (state_q)
            CH_INIT: begin
                if (!hold_mode) begin
                    oe_o  = 1'b1;
                    off_o = 1'b0;
                end
            end
            CH_OFF: begin
                oe_o  = 1'b0;
                off_o = 1'b1;
            end
            CH_ZERO: begin
                oe_o  = 1'b1;
                off_o = 1'b0;
            end
            CH_FULL: begin
                code_o = FULL_CODE;
                oe_o   = 1'b1;
                off_o  = 1'b0;
            end
            CH_DRIVE, CH_HOLD: begin
                code_o = code_q;
                oe_o   = 1'b1;
                off_o  = 1'b0;
            end
            default: begin
                oe_o  = 1'b0;
                off_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/pwm_idle_ctrl.sv
module pwm_idle_ctrl #(
    parameter int NUM_CH        = 4,
    parameter int CODE_W        = 12,
    parameter int PRESCALE      = 50000,
    parameter int TIMEOUT_TICKS = 60
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hold_mode,
    input  logic                     sleep_n,
    input  logic                     ext_ref,
    input  logic [NUM_CH-1:0]        pwm_level,
    input  logic [NUM_CH-1:0]        pwm_rise,
    input  logic [NUM_CH-1:0]        conv_valid,
    input  logic [NUM_CH*CODE_W-1:0] conv_code,
    output logic [NUM_CH*CODE_W-1:0] dac_code,
    output logic [NUM_CH-1:0]        drive_en,
    output logic [NUM_CH-1:0]        chan_off,
    output logic                     ref_off
);
    logic              tick;
    logic [NUM_CH-1:0] idle;
    logic [NUM_CH-1:0] expire;
    logic [NUM_CH-1:0] timer_clr;

    idle_tick_gen #(.PRESCALE(PRESCALE)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        idle_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) timer_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick),
            .clr_i    (timer_clr[ch]),
            .idle_o   (idle[ch]),
            .expire_o (expire[ch])
        );

        chan_ctrl #(.CODE_W(CODE_W)) ctrl_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .hold_mode   (hold_mode),
            .sleep_n     (sleep_n),
            .lvl_i       (pwm_level[ch]),
            .rise_i      (pwm_rise[ch]),
            .code_vld_i  (conv_valid[ch]),
            .code_i      (conv_code[ch*CODE_W +: CODE_W]),
            .idle_i      (idle[ch]),
            .expire_i    (expire[ch]),
            .timer_clr_o (timer_clr[ch]),
            .code_o      (dac_code[ch*CODE_W +: CODE_W]),
            .oe_o        (drive_en[ch]),
            .off_o       (chan_off[ch])
        );
    end

    // reference sleeps with an external reference or when no channel is awake
    assign ref_off = ext_ref || (&chan_off);
endmodule

// File: rtl/pwm_idle_ctrl_chk.sv
module pwm_idle_ctrl_chk #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     hold_mode,
    input logic                     sleep_n,
    input logic                     ext_ref,
    input logic [NUM_CH-1:0]        conv_valid,
    input logic [NUM_CH*CODE_W-1:0] dac_code,
    input logic [NUM_CH-1:0]        drive_en,
    input logic [NUM_CH-1:0]        chan_off,
    input logic                     ref_off
);
    a_r7_sleep_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n |=> ((&chan_off) && (drive_en == '0) && ref_off));

    a_r9_ext_ref_off: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ref |-> ref_off);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        a_r6_off_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            chan_off[i] |-> (!drive_en[i] && (dac_code[i*CODE_W +: CODE_W] == '0)));

        a_r8_transparent_live: assert property (@(posedge clk) disable iff (!rst_n)
            (!hold_mode && sleep_n) |=> drive_en[i]);

        a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (hold_mode && drive_en[i] && $past(drive_en[i]) && !$past(conv_valid[i]))
            |-> $stable(dac_code[i*CODE_W +: CODE_W]));

        a_r9_ref_awake: assert property (@(posedge clk) disable iff (!rst_n)
            (!ext_ref && !chan_off[i]) |-> !ref_off);
    end
endmodule

bind pwm_idle_ctrl pwm_idle_ctrl_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) chk_i (.*);

// File: tb/pwm_idle_ctrl_tb_top.sv
module pwm_idle_ctrl_tb_top;
    localparam int NUM_CH = 4;
    localparam int CODE_W = 12;
    localparam int PRESCALE = 4;
    localparam int TIMEOUT_TICKS = 8;
    localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     hold_mode = 1'b0;
    logic                     sleep_n = 1'b1;
    logic                     ext_ref = 1'b0;
    logic [NUM_CH-1:0]        pwm_level = '0;
    logic [NUM_CH-1:0]        pwm_rise = '0;
    logic [NUM_CH-1:0]        conv_valid = '0;
    logic [NUM_CH*CODE_W-1:0] conv_code = '0;
    logic [NUM_CH*CODE_W-1:0] dac_code;
    logic [NUM_CH-1:0]        drive_en;
    logic [NUM_CH-1:0]        chan_off;
    logic                     ref_off;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwm_idle_ctrl #(
        .NUM_CH(NUM_CH), .CODE_W(CODE_W),
        .PRESCALE(PRESCALE), .TIMEOUT_TICKS(TIMEOUT_TICKS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .hold_mode(hold_mode), .sleep_n(sleep_n),
        .ext_ref(ext_ref), .pwm_level(pwm_level), .pwm_rise(pwm_rise),
        .conv_valid(conv_valid), .conv_code(conv_code), .dac_code(dac_code),
        .drive_en(drive_en), .chan_off(chan_off), .ref_off(ref_off)
    );

    function automatic logic [CODE_W-1:0] code_of(input int ch);
        return dac_code[ch*CODE_W +: CODE_W];
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0;
        hold_mode = mode;
        sleep_n = 1'b1;
        pwm_level = '0;
        pwm_rise = '0;
        conv_valid = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic rise(input int ch);
        pwm_level[ch] = 1'b1;
        pwm_rise[ch] = 1'b1;
        @(negedge clk);
        pwm_rise[ch] = 1'b0;
    endtask

    task automatic strobe(input int ch, input logic [CODE_W-1:0] code);
        conv_valid[ch] = 1'b1;
        conv_code[ch*CODE_W +: CODE_W] = code;
        @(negedge clk);
        conv_valid[ch] = 1'b0;
    endtask

    // two close rising edges then a strobe; a = clock of the second edge
    task automatic pair(input int ch, input logic [CODE_W-1:0] code,
                        input bit keep_high, output int a);
        rise(ch);
        @(negedge clk);
        pwm_level[ch] = 1'b0;
        repeat (2) @(negedge clk);
        rise(ch);
        a = cyc;
        strobe(ch, code);
        if (!keep_high) pwm_level[ch] = 1'b0;
    endtask

    task automatic t_reset_transparent();
        do_reset(1'b0);
        chk("R1", "transparent drive_en", 32'(drive_en), 32'hF);
        chk("R1", "transparent chan_off", 32'(chan_off), 32'h0);
        chk("R1", "transparent codes", 32'(dac_code[31:0]), 32'h0);
        chk("R9", "ref awake", 32'(ref_off), 32'h0);
    endtask

    task automatic t_update();
        int a;
        pair(0, 12'h5A3, 1'b0, a);
        chk("R2", "ch0 code", 32'(code_of(0)), 32'h5A3);
        chk("R2", "ch0 drive_en", 32'(drive_en[0]), 32'h1);
        chk("R11", "ch1 untouched", 32'(code_of(1)), 32'h0);
        chk("R11", "ch3 untouched", 32'(code_of(3)), 32'h0);
    endtask

    task automatic t_reject();
        int a;
        strobe(1, 12'h0AB);
        chk("R3", "strobe with no edge", 32'(code_of(1)), 32'h0);
        rise(1);
        pwm_level[1] = 1'b0;
        repeat (40) @(negedge clk);
        rise(1);
        pwm_level[1] = 1'b0;
        strobe(1, 12'h111);
        chk("R3", "pair wider than timeout", 32'(code_of(1)), 32'h0);
        @(negedge clk);
        rise(1);
        pwm_level[1] = 1'b0;
        strobe(1, 12'h222);
        chk("R2", "single valid pair", 32'(code_of(1)), 32'h222);
        a = cyc;
    endtask

    task automatic t_timeout_low();
        int a;
        pair(2, 12'h123, 1'b0, a);
        wait_to(a + 28);
        chk("R4", "no idle before window", 32'(code_of(2)), 32'h123);
        wait_to(a + 33);
        chk("R4", "idle after window", 32'(code_of(2)), 32'h0);
        chk("R5", "idle low drives zero", 32'(drive_en[2]), 32'h1);
    endtask

    task automatic t_idle_high();
        int a;
        int f;
        pair(3, 12'h3C3, 1'b1, a);
        chk("R2", "ch3 code", 32'(code_of(3)), 32'h3C3);
        wait_to(a + 40);
        chk("R5", "idle high full-scale", 32'(code_of(3)), 32'(FULL));
        pwm_level[3] = 1'b0;
        @(negedge clk);
        f = cyc;
        wait_to(f + 20);
        chk("R5", "timeout restarts at fall", 32'(code_of(3)), 32'(FULL));
        wait_to(f + 40);
        chk("R5", "full-scale to zero", 32'(code_of(3)), 32'h0);
    endtask

    task automatic t_priority();
        int a;
        int b;
        int a2;
        int s;
        pair(0, 12'h456, 1'b0, a);
        while (code_of(0) == 12'h456 && cyc < a + 60) @(negedge clk);
        b = cyc;
        chk("R4", "expiry inside window", 32'((b - a >= 29) && (b - a <= 32)), 32'h1);
        a2 = a + 4 * ((b - a) / 4 + 12);
        wait_to(a2 - 5);
        rise(0);
        pwm_level[0] = 1'b0;
        wait_to(a2 - 1);
        rise(0);
        pwm_level[0] = 1'b0;
        s = a2 + (b - a);
        wait_to(s - 1);
        strobe(0, 12'h789);
        chk("R10", "code beats expiry", 32'(code_of(0)), 32'h789);
        wait_to(s + 45);
        chk("R10", "code kept after expiry", 32'(code_of(0)), 32'h789);
    endtask

    task automatic t_ref();
        ext_ref = 1'b1;
        @(negedge clk);
        chk("R9", "external reference", 32'(ref_off), 32'h1);
        ext_ref = 1'b0;
        @(negedge clk);
        chk("R9", "internal reference awake", 32'(ref_off), 32'h0);
    endtask

    task automatic t_sleep_transparent();
        int a;
        pair(0, 12'h5A5, 1'b0, a);
        sleep_n = 1'b0;
        @(negedge clk);
        chk("R7", "all off", 32'(chan_off), 32'hF);
        chk("R7", "codes zero", 32'(code_of(0)), 32'h0);
        chk("R7", "ref off", 32'(ref_off), 32'h1);
        sleep_n = 1'b1;
        @(negedge clk);
        chk("R8", "transparent resumes", 32'(drive_en), 32'hF);
        chk("R8", "resume at zero", 32'(code_of(0)), 32'h0);
    endtask

    task automatic t_sample_hold();
        int a;
        int r;
        do_reset(1'b1);
        chk("R1", "sample/hold drive_en", 32'(drive_en), 32'h0);
        chk("R1", "sample/hold chan_off", 32'(chan_off), 32'hF);
        chk("R9", "all off ref off", 32'(ref_off), 32'h1);
        pair(1, 12'h7C1, 1'b1, a);
        chk("R2", "ch1 wakes with code", 32'(code_of(1)), 32'h7C1);
        chk("R9", "ref awake", 32'(ref_off), 32'h0);
        wait_to(a + 40);
        chk("R6", "idle high holds", 32'(code_of(1)), 32'h7C1);
        pwm_level[1] = 1'b0;
        repeat (3) @(negedge clk);
        rise(1);
        r = cyc;
        strobe(1, 12'h0AA);
        chk("R3", "late pair ignored", 32'(code_of(1)), 32'h7C1);
        pwm_level[1] = 1'b0;
        wait_to(r + 40);
        chk("R6", "idle low powers down", 32'(chan_off[1]), 32'h1);
        chk("R6", "powered-down code", 32'(code_of(1)), 32'h0);
        rise(2);
        repeat (40) @(negedge clk);
        chk("R6", "off stays off idle high", 32'(drive_en[2]), 32'h0);
        pwm_level[2] = 1'b0;
    endtask

    task automatic t_sleep_hold();
        int a;
        pair(0, 12'h321, 1'b0, a);
        chk("R2", "ch0 code", 32'(code_of(0)), 32'h321);
        sleep_n = 1'b0;
        @(negedge clk);
        chk("R7", "all off", 32'(chan_off), 32'hF);
        strobe(0, 12'h0F0);
        chk("R7", "strobe in sleep ignored", 32'(drive_en[0]), 32'h0);
        sleep_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8", "still off after release", 32'(chan_off), 32'hF);
        rise(0);
        pwm_level[0] = 1'b0;
        strobe(0, 12'h0F0);
        chk("R8", "one edge not enough", 32'(drive_en[0]), 32'h0);
        rise(0);
        pwm_level[0] = 1'b0;
        strobe(0, 12'h0E1);
        chk("R8", "second edge wakes", 32'(code_of(0)), 32'h0E1);
        chk("R11", "ch3 still off", 32'(chan_off[3]), 32'h1);
    endtask

    initial begin
        t_reset_transparent();
        t_update();
        t_reject();
        t_timeout_low();
        t_idle_high();
        t_priority();
        t_ref();
        t_sleep_transparent();
        t_sample_hold();
        t_sleep_hold();
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not end, actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule